// File: doc/BRIEF.md
# Staged Bit-Permutation Unit (reverse, OR-combine, shuffle, unshuffle)

This block rearranges the bits of a 64-bit word through a chain of butterfly stages. A 6-bit control amount switches each stage on or off. The block offers four functions. Generalized reverse exchanges neighbouring bit groups of size 1, 2, 4, 8, 16 or 32. OR-combine merges every group with its exchanged partner. Shuffle interleaves groups. Unshuffle undoes shuffle exactly. All four functions run through one shared set of stage masks. Shuffle walks its stages from the widest to the narrowest, and unshuffle walks them in the opposite direction.

A word-mode flag restricts the operation to the low 32 bits. The datapath is purely combinational. Its result is captured in an output register one cycle after the operands are presented with `inValid`, and `outValid` marks that captured result. Opcode decoding and register-file access belong to the surrounding pipeline.

Top module: `bitperm_unit`

## Requirements
- R1: With `opSel`=0 (reverse), result bit i equals input bit (i XOR amt), where amt is `ctrlAmt[5:0]` in 64-bit mode.
- R2: With `opSel`=1 (OR-combine), result bit i is the OR of input bits (i XOR m) over every m whose set bits are a subset of amt. The result therefore always contains every set bit of the input.
- R3: With `opSel`=2 (shuffle), amount bit s (s=4..0, group size N=2^s) enables one stage, and the stages are applied in the order s=4,3,2,1,0. In each stage, bits outside maskL|maskR keep their value, (x<<N) fills maskL and (x>>N) fills maskR. maskL holds bit positions i where i[s+1]=1 and i[s]=0, and maskR holds positions where i[s+1]=0 and i[s]=1 (for example, N=1 gives 0x4444… and 0x2222…).
- R4: With `opSel`=3 (unshuffle), the same stages are applied in the order s=0,1,2,3,4, so unshuffle(shuffle(x,c),c)=x for every c.
- R5: Shuffle and unshuffle ignore `ctrlAmt[5]` in 64-bit mode.
- R6: When `wordMode`=1, input bits 63:32 have no effect and result bits 63:32 are zero. Reverse and OR-combine use only `ctrlAmt[4:0]`, and shuffle/unshuffle use only `ctrlAmt[3:0]`.
- R7: A result presented with `inValid`=1 at one rising edge appears on `dataOut` with `outValid`=1 after that edge. `outValid` is low after any edge where `inValid` was low.
- R8: `dataOut` holds its value across edges where `inValid` is low.
- R9: During and after reset, `dataOut` is zero and `outValid` is low until the first accepted operation.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands valid; the result is captured at this edge |
| dataIn | input | 64 | Word to permute |
| ctrlAmt | input | 6 | Stage-enable amount |
| opSel | input | 2 | 0 reverse, 1 OR-combine, 2 shuffle, 3 unshuffle |
| wordMode | input | 1 | Restrict to the low 32 bits |
| dataOut | output | 64 | Registered permuted word |
| outValid | output | 1 | dataOut holds a freshly captured result |

## Verification
The word-mode restriction and the widest permitted stage can act in the same cycle. This is provoked by issuing word-mode operations whose amount has bit 4 or bit 5 set together with set bits in the upper input half. Each result is judged against a bench model that first clears the upper half and masks the amount, and the check requires the upper result half to be zero. Loading a new result and holding the previous one also meet at the same register. This is provoked by alternating issue and idle cycles while `dataIn` keeps changing, and it is judged by comparing `dataOut` before and after the idle edges.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;
  localparam int DATA_W = 64;
  localparam int AMT_W  = 6;
  localparam int REV_STAGES  = AMT_W;
  localparam int SHUF_STAGES = AMT_W - 1;

  typedef enum logic [1:0] {
    OP_REV    = 2'd0,
    OP_ORC    = 2'd1,
    OP_SHUF   = 2'd2,
    OP_UNSHUF = 2'd3
  } permOp_e;

  typedef struct packed {
    logic             load;
    logic [AMT_W-1:0] stageEn;
    logic             orMode;
    logic             shufMode;
    logic             unshufDir;
    logic             wordMode;
  } permStrobe_t;
endpackage

// File: rtl/bitperm_ctrl.sv
module bitperm_ctrl
  import bitperm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [AMT_W-1:0] ctrlAmt,
  input  logic [1:0]       opSel,
  input  logic             wordMode,
  output permStrobe_t      strobes,
  output logic             outValid
);
  logic [AMT_W-1:0] amtMask;
  logic             isShuf;

  assign isShuf = (opSel == OP_SHUF) || (opSel == OP_UNSHUF);

  always_comb begin
    amtMask = '1;
    if (isShuf) amtMask[AMT_W-1] = 1'b0;
    if (wordMode) begin
      amtMask[AMT_W-1] = 1'b0;
      if (isShuf) amtMask[AMT_W-2] = 1'b0;
    end
  end

  always_comb begin
    strobes.load      = inValid;
    strobes.stageEn   = ctrlAmt & amtMask;
    strobes.orMode    = (opSel == OP_ORC);
    strobes.shufMode  = isShuf;
    strobes.unshufDir = (opSel == OP_UNSHUF);
    strobes.wordMode  = wordMode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

  // R7
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  // R7
  valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
endmodule

// File: rtl/bitperm_dpath.sv
module bitperm_dpath
  import bitperm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  permStrobe_t       strobes,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] revLoMask(input int k);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (((i >> k) & 1) == 0);
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] shufMask(input int s, input bit leftSide);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) begin
      if (leftSide) m[i] = (((i >> (s + 1)) & 1) == 1) && (((i >> s) & 1) == 0);
      else          m[i] = (((i >> (s + 1)) & 1) == 0) && (((i >> s) & 1) == 1);
    end
    return m;
  endfunction

  logic [DATA_W-1:0] srcW;
  logic [DATA_W-1:0] revChain [REV_STAGES+1];
  logic [DATA_W-1:0] fwdChain [SHUF_STAGES+1];
  logic [DATA_W-1:0] bwdChain [SHUF_STAGES+1];
  logic [DATA_W-1:0] result;

  assign srcW = strobes.wordMode ? {{HALF_W{1'b0}}, dataIn[HALF_W-1:0]} : dataIn;
  assign revChain[0] = srcW;
  assign fwdChain[0] = srcW;
  assign bwdChain[0] = srcW;

  for (genvar k = 0; k < REV_STAGES; k++) begin : g_rev
    localparam int SH = 1 << k;
    localparam logic [DATA_W-1:0] LO = revLoMask(k);
    logic [DATA_W-1:0] swapped;
    assign swapped = ((revChain[k] & LO) << SH) | ((revChain[k] & ~LO) >> SH);
    assign revChain[k+1] = !strobes.stageEn[k] ? revChain[k] :
                           strobes.orMode ? (revChain[k] | swapped) : swapped;
  end

  for (genvar j = 0; j < SHUF_STAGES; j++) begin : g_shuf
    localparam int SF = SHUF_STAGES - 1 - j;
    localparam int NF = 1 << SF;
    localparam logic [DATA_W-1:0] FL = shufMask(SF, 1'b1);
    localparam logic [DATA_W-1:0] FR = shufMask(SF, 1'b0);
    localparam int SB = j;
    localparam int NB = 1 << SB;
    localparam logic [DATA_W-1:0] BL = shufMask(SB, 1'b1);
    localparam logic [DATA_W-1:0] BR = shufMask(SB, 1'b0);
    logic [DATA_W-1:0] fwdNext;
    logic [DATA_W-1:0] bwdNext;
    assign fwdNext = (fwdChain[j] & ~(FL | FR)) | ((fwdChain[j] << NF) & FL)
                   | ((fwdChain[j] >> NF) & FR);
    assign bwdNext = (bwdChain[j] & ~(BL | BR)) | ((bwdChain[j] << NB) & BL)
                   | ((bwdChain[j] >> NB) & BR);
    assign fwdChain[j+1] = strobes.stageEn[SF] ? fwdNext : fwdChain[j];
    assign bwdChain[j+1] = strobes.stageEn[SB] ? bwdNext : bwdChain[j];
  end

  always_comb begin
    if (!strobes.shufMode)      result = revChain[REV_STAGES];
    else if (strobes.unshufDir) result = bwdChain[SHUF_STAGES];
    else                        result = fwdChain[SHUF_STAGES];
    if (strobes.wordMode) result[DATA_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            dataOut <= '0;
    else if (strobes.load) dataOut <= result;
  end

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.load |=> $stable(dataOut));
  // R6
  word_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.load && strobes.wordMode) |=> (dataOut[DATA_W-1:HALF_W] == '0));
  // R2
  orc_superset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.load && strobes.orMode && !strobes.shufMode && !strobes.wordMode)
      |=> ((dataOut & $past(dataIn)) == $past(dataIn)));
endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit
  import bitperm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [63:0] dataIn,
  input  logic [5:0]  ctrlAmt,
  input  logic [1:0]  opSel,
  input  logic        wordMode,
  output logic [63:0] dataOut,
  output logic        outValid
);
  permStrobe_t strobes;

  bitperm_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .ctrlAmt  (ctrlAmt),
    .opSel    (opSel),
    .wordMode (wordMode),
    .strobes  (strobes),
    .outValid (outValid)
  );

  bitperm_dpath dpath_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (dataOut == 64'd0 && !outValid));
endmodule

// File: tb/bitperm_unit_tb.sv
module bitperm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] dataIn = '0;
  logic [5:0]  ctrlAmt = '0;
  logic [1:0]  opSel = '0;
  logic        wordMode = 1'b0;
  logic [63:0] dataOut;
  logic        outValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bitperm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .dataIn(dataIn),
    .ctrlAmt(ctrlAmt), .opSel(opSel), .wordMode(wordMode),
    .dataOut(dataOut), .outValid(outValid)
  );

  // {op[1:0], word, amt[5:0], data[63:0], expected[63:0]}
  localparam int NVEC = 11;
  localparam logic [136:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 6'd63, 64'h1, 64'h8000000000000000},        // R1
    {2'd0, 1'b0, 6'd0,  64'h0123456789ABCDEF, 64'h0123456789ABCDEF}, // R1
    {2'd1, 1'b0, 6'd1,  64'h1, 64'h3},                       // R2
    {2'd1, 1'b0, 6'd63, 64'h1, 64'hFFFFFFFFFFFFFFFF},        // R2
    {2'd2, 1'b0, 6'd16, 64'h00000000FFFF0000, 64'h0000FFFF00000000}, // R3
    {2'd2, 1'b0, 6'd1,  64'h4, 64'h2},                       // R3
    {2'd3, 1'b0, 6'd16, 64'h0000FFFF00000000, 64'h00000000FFFF0000}, // R4
    {2'd2, 1'b0, 6'd32, 64'hDEADBEEF01234567, 64'hDEADBEEF01234567}, // R5
    {2'd0, 1'b1, 6'd31, 64'hFFFFFFFF00000001, 64'h0000000080000000}, // R6
    {2'd0, 1'b1, 6'd32, 64'h1, 64'h1},                       // R6
    {2'd2, 1'b1, 6'd16, 64'h00000000FFFF0000, 64'h00000000FFFF0000}  // R6
  };

  function automatic logic [63:0] mRev(input logic [63:0] x, input logic [5:0] a);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = x[i ^ int'(a)];
    return r;
  endfunction

  function automatic logic [63:0] mOrc(input logic [63:0] x, input logic [5:0] a);
    logic [63:0] r = '0;
    for (int m = 0; m < 64; m++)
      if ((m & ~int'(a)) == 0) r |= mRev(x, 6'(m));
    return r;
  endfunction

  function automatic logic [63:0] mStage(input logic [63:0] x, input int s);
    logic [63:0] l, r;
    case (s)
      4: begin l = 64'h0000FFFF00000000; r = 64'h00000000FFFF0000; end
      3: begin l = 64'h00FF000000FF0000; r = 64'h0000FF000000FF00; end
      2: begin l = 64'h0F000F000F000F00; r = 64'h00F000F000F000F0; end
      1: begin l = 64'h3030303030303030; r = 64'h0C0C0C0C0C0C0C0C; end
      default: begin l = 64'h4444444444444444; r = 64'h2222222222222222; end
    endcase
    return (x & ~(l | r)) | ((x << (1 << s)) & l) | ((x >> (1 << s)) & r);
  endfunction

  function automatic logic [63:0] model(input logic [1:0] op, input logic wm,
                                        input logic [5:0] a, input logic [63:0] d);
    logic [63:0] x = d;
    logic [5:0] am = a;
    if (op >= 2) am[5] = 1'b0;
    if (wm) begin
      x[63:32] = '0;
      am[5] = 1'b0;
      if (op >= 2) am[4] = 1'b0;
    end
    case (op)
      2'd0: x = mRev(x, am);
      2'd1: x = mOrc(x, am);
      2'd2: for (int s = 4; s >= 0; s--) if (am[s]) x = mStage(x, s);
      default: for (int s = 0; s <= 4; s++) if (am[s]) x = mStage(x, s);
    endcase
    if (wm) x[63:32] = '0;
    return x;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic wm, input logic [5:0] a,
                       input logic [63:0] d);
    @(negedge clk);
    opSel = op; wordMode = wm; ctrlAmt = a; dataIn = d; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    dataIn = ~d;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [6];
    logic [63:0] held, y;
    pats[0] = 64'h0123456789ABCDEF; pats[1] = 64'h8000000000000001;
    pats[2] = 64'hF0F0F0F00F0F0F0F; pats[3] = 64'hA5A5A5A5A5A5A5A5;
    pats[4] = 64'h0000000100010000; pats[5] = 64'hFEDCBA9876543210;

    repeat (3) @(negedge clk);
    check("R9 reset dataOut", dataOut, 64'd0);
    check("R9 reset outValid", {63'd0, outValid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", {63'd0, outValid}, 64'd0);

    for (int v = 0; v < NVEC; v++) begin
      issue(VEC[v][136:135], VEC[v][134], VEC[v][133:128], VEC[v][127:64]);
      check($sformatf("R1-table vec%0d", v), dataOut, VEC[v][63:0]);
      check("R7 outValid high", {63'd0, outValid}, 64'd1);
    end

    for (int p = 0; p < 6; p++)
      for (int o = 0; o < 4; o++)
        for (int a = 0; a < 64; a += 7)
          for (int w = 0; w < 2; w++) begin
            issue(2'(o), w[0], 6'(a), pats[p]);
            check($sformatf("R%0d model op%0d", (w != 0) ? 6 : o + 1, o), dataOut,
                  model(2'(o), w[0], 6'(a), pats[p]));
          end

    // R4: unshuffle inverts shuffle for every amount
    for (int a = 0; a < 64; a++) begin
      issue(2'd2, 1'b0, 6'(a), pats[a % 6]);
      y = dataOut;
      issue(2'd3, 1'b0, 6'(a), y);
      check("R4 round trip", dataOut, pats[a % 6]);
    end

    // R6: word mode with upper input garbage, top stages requested
    issue(2'd2, 1'b1, 6'd31, 64'hFFFFFFFF12345678);
    check("R6 word shuffle", dataOut, model(2'd2, 1'b0, 6'd15, 64'h0000000012345678));
    issue(2'd1, 1'b1, 6'd63, 64'hFFFFFFFF00000001);
    check("R6 word orc", dataOut, 64'h00000000FFFFFFFF);

    // R8 and R7: idle edges hold the output and drop valid
    issue(2'd0, 1'b0, 6'd5, 64'h0F);
    held = dataOut;
    check("R1 rev amt5", held, mRev(64'h0F, 6'd5));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      dataIn = dataIn + 64'h1111;
      ctrlAmt = 6'(k + 9);
    end
    check("R8 hold", dataOut, held);
    check("R7 valid low when idle", {63'd0, outValid}, 64'd0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule